// File: doc/BRIEF.md
# Non-Overlapping Two-Phase Clock Generator

This block turns one fast system clock into a pair of slower phase signals, `phi1_o` and `phi2_o`, that are never high together. Each output period runs through four segments in a fixed order: `phi1_o` high, a dead band with both phases low, `phi2_o` high, and a second dead band. Each segment lasts a whole number of system-clock ticks, and those counts are parameters. A one-tick strobe marks the first tick of every period, so downstream logic can align with the start of a cycle.

The generator runs only while its enable is high and reset is low. Dropping the enable, or asserting the synchronous reset, forces both phases low. The period restarts from its first tick once the block is allowed to run again. All three outputs come straight from flip-flops, so decode glitches cannot cause an overlap. The defaults describe a 20-tick period: 9 ticks of `phi1_o`, 1 dead tick, 9 ticks of `phi2_o` and 1 dead tick.

Top module: `nonoverlap_clkgen`

## Requirements
- R1: While `rst_i` is sampled high at a rising edge, `phi1_o`, `phi2_o` and `strobe_o` are all low after that edge.
- R2: The first rising edge that samples `rst_i` low and `en_i` high starts tick 0 of a period. `phi1_o` is high for ticks 0 to P1_HIGH-1 and never stays high longer than P1_HIGH consecutive ticks.
- R3: After `phi1_o` falls, both phases stay low for exactly GAP_TICKS ticks before `phi2_o` rises.
- R4: `phi2_o` is high for exactly P2_HIGH consecutive ticks. After it falls, both phases are low for GAP_TICKS ticks.
- R5: `phi1_o` and `phi2_o` are never high in the same tick.
- R6: `strobe_o` is high only on tick 0 of a period, which is the tick where `phi1_o` rises, and it lasts one tick.
- R7: An edge that samples `en_i` low forces all outputs low after that edge. The next enabled edge restarts at tick 0, with the strobe and `phi1_o` high.
- R8: While enabled, the pattern repeats every P1_HIGH + P2_HIGH + 2*GAP_TICKS ticks, with a strobe at the start of each repeat.
- R9: Elaboration is rejected if GAP_TICKS, P1_HIGH or P2_HIGH is below one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; every segment length is counted in its ticks |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low holds both phases low and restarts the period |
| phi1_o | output | 1 | First phase, high during the opening segment of each period |
| phi2_o | output | 1 | Second phase, high after the first dead band |
| strobe_o | output | 1 | One-tick marker on the first tick of each period |

## Verification
The assertions assume that `en_i` and `rst_i` change only between rising edges and hold steady across each sampling edge. They also assume the dead-band check applies only to a rise of `phi2_o`, because an enable pulse may cut a period short at any tick. The stimulus drives both inputs on falling edges. It drops the enable partway through a high phase and asserts reset partway through a running period, so that truncated periods and restarts are exercised. The bench sets unequal phase lengths and a two-tick gap, so that a swapped or miscounted segment shows up.

// File: rtl/ncg_pkg.sv
package ncg_pkg;

    // Segment order inside one output period; the increment order is the sequence.
    typedef enum logic [1:0] {
        SEG_PH1   = 2'd0,
        SEG_DEADA = 2'd1,
        SEG_PH2   = 2'd2,
        SEG_DEADB = 2'd3
    } seg_e;

endpackage

// File: rtl/ncg_seq.sv
module ncg_seq
    import ncg_pkg::*;
#(
    parameter int P1_HIGH   = 9,
    parameter int P2_HIGH   = 9,
    parameter int GAP_TICKS = 1,
    parameter int CNT_W     = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic             run_d_o,
    output seg_e             seg_d_o,
    output logic             first_d_o
);

    localparam logic [CNT_W-1:0] LIM_PH1 = CNT_W'(P1_HIGH - 1);
    localparam logic [CNT_W-1:0] LIM_PH2 = CNT_W'(P2_HIGH - 1);
    localparam logic [CNT_W-1:0] LIM_GAP = CNT_W'(GAP_TICKS - 1);

    typedef struct packed {
        logic             run;
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s seq_d, seq_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        unique case (seq_q.seg)
            SEG_PH1: lim = LIM_PH1;
            SEG_PH2: lim = LIM_PH2;
            default: lim = LIM_GAP;
        endcase
    end

    always_comb begin
        seq_d = seq_q;
        if (rst_i || !en_i) begin
            seq_d.run = 1'b0;
            seq_d.seg = SEG_PH1;
            seq_d.cnt = '0;
        end else if (!seq_q.run) begin
            seq_d.run = 1'b1;
            seq_d.seg = SEG_PH1;
            seq_d.cnt = '0;
        end else if (seq_q.cnt == lim) begin
            seq_d.seg = seg_e'(2'(seq_q.seg + 2'd1));
            seq_d.cnt = '0;
        end else begin
            seq_d.cnt = seq_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        seq_q <= seq_d;
    end

    assign run_d_o   = seq_d.run;
    assign seg_d_o   = seq_d.seg;
    assign first_d_o = (seq_d.seg == SEG_PH1) && (seq_d.cnt == '0);

endmodule

// File: rtl/ncg_drive.sv
module ncg_drive
    import ncg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_d_i,
    input  seg_e seg_d_i,
    input  logic first_d_i,
    output logic phi1_o,
    output logic phi2_o,
    output logic strobe_o
);

    typedef struct packed {
        logic phi1;
        logic phi2;
        logic strobe;
    } drv_s;

    drv_s drv_d, drv_q;

    always_comb begin
        drv_d.phi1   = run_d_i && (seg_d_i == SEG_PH1);
        drv_d.phi2   = run_d_i && (seg_d_i == SEG_PH2);
        drv_d.strobe = run_d_i && (seg_d_i == SEG_PH1) && first_d_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) drv_q <= '0;
        else       drv_q <= drv_d;
    end

    assign phi1_o   = drv_q.phi1;
    assign phi2_o   = drv_q.phi2;
    assign strobe_o = drv_q.strobe;

endmodule

// File: rtl/nonoverlap_clkgen.sv
module nonoverlap_clkgen
    import ncg_pkg::*;
#(
    parameter int P1_HIGH   = 9,
    parameter int P2_HIGH   = 9,
    parameter int GAP_TICKS = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    output logic phi1_o,
    output logic phi2_o,
    output logic strobe_o
);

    localparam int MAX_LEN = (P1_HIGH > P2_HIGH)
                           ? ((P1_HIGH > GAP_TICKS) ? P1_HIGH : GAP_TICKS)
                           : ((P2_HIGH > GAP_TICKS) ? P2_HIGH : GAP_TICKS);
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    // R9: lengths below one tick are rejected at elaboration
    generate
        if (GAP_TICKS < 1) begin : g_bad_gap
            $error("nonoverlap_clkgen: GAP_TICKS must be at least 1");
        end
        if (P1_HIGH < 1 || P2_HIGH < 1) begin : g_bad_high
            $error("nonoverlap_clkgen: phase high lengths must be at least 1");
        end
    endgenerate

    logic run_d;
    seg_e seg_d;
    logic first_d;

    ncg_seq #(
        .P1_HIGH  (P1_HIGH),
        .P2_HIGH  (P2_HIGH),
        .GAP_TICKS(GAP_TICKS),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .run_d_o  (run_d),
        .seg_d_o  (seg_d),
        .first_d_o(first_d)
    );

    ncg_drive u_drive (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_d_i  (run_d),
        .seg_d_i  (seg_d),
        .first_d_i(first_d),
        .phi1_o   (phi1_o),
        .phi2_o   (phi2_o),
        .strobe_o (strobe_o)
    );

endmodule

// File: rtl/nonoverlap_clkgen_chk.sv
module nonoverlap_clkgen_chk #(
    parameter int P1_HIGH   = 9,
    parameter int P2_HIGH   = 9,
    parameter int GAP_TICKS = 1
) (
    input logic clk_i,
    input logic rst_i,
    input logic en_i,
    input logic phi1_o,
    input logic phi2_o,
    input logic strobe_o
);

    int run1, run2, dead;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run1 <= 0;
            run2 <= 0;
            dead <= 0;
        end else begin
            run1 <= phi1_o ? run1 + 1 : 0;
            run2 <= phi2_o ? run2 + 1 : 0;
            dead <= (phi1_o || phi2_o) ? 0 : ((dead < GAP_TICKS) ? dead + 1 : dead);
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk_i)
        rst_i |=> (!phi1_o && !phi2_o && !strobe_o));

    assert_phi1_len_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        phi1_o |-> (run1 < P1_HIGH));

    assert_dead_band_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(phi2_o) |-> (dead >= GAP_TICKS));

    assert_phi2_len_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        phi2_o |-> (run2 < P2_HIGH));

    assert_no_overlap_R5: assert property (@(posedge clk_i)
        !(phi1_o && phi2_o));

    assert_strobe_on_rise_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |-> $rose(phi1_o));

    assert_disabled_low_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!phi1_o && !phi2_o && !strobe_o));

endmodule

bind nonoverlap_clkgen nonoverlap_clkgen_chk #(
    .P1_HIGH  (P1_HIGH),
    .P2_HIGH  (P2_HIGH),
    .GAP_TICKS(GAP_TICKS)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .phi1_o  (phi1_o),
    .phi2_o  (phi2_o),
    .strobe_o(strobe_o)
);

// File: tb/sim_nonoverlap_clkgen.sv
`timescale 1ns/1ps
module sim_nonoverlap_clkgen;

    localparam int H1  = 6;
    localparam int H2  = 4;
    localparam int GAP = 2;
    localparam int PER = H1 + H2 + 2 * GAP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic phi1, phi2, strobe;

    int checks   = 0;
    int failures = 0;
    int tick     = -1;   // position within period, -1 when idle
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    nonoverlap_clkgen #(
        .P1_HIGH  (H1),
        .P2_HIGH  (H2),
        .GAP_TICKS(GAP)
    ) u0 (
        .clk_i   (clk),
        .rst_i   (rst),
        .en_i    (en),
        .phi1_o  (phi1),
        .phi2_o  (phi2),
        .strobe_o(strobe)
    );

    // behavioural reference: tick index advanced on every rising edge
    always @(posedge clk) begin
        if (rst || !en) tick <= -1;
        else            tick <= (tick + 1) % PER;
    end

    task automatic check_bit(input string req, input string what,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at tick %0d time %0t",
                     req, what, act, exp, tick, $time);
        end
    endtask

    task automatic compare_now(input bit was_rst);
        logic e1, e2, es;
        string tag;
        e1 = (tick >= 0) && (tick < H1);
        e2 = (tick >= H1 + GAP) && (tick < H1 + GAP + H2);
        es = (tick == 0);
        if (tick < 0)                   tag = was_rst ? "R1" : "R7";
        else if (tick < H1)             tag = "R2";
        else if (tick < H1 + GAP)       tag = "R3";
        else if (tick < H1 + GAP + H2)  tag = "R4";
        else                            tag = "R4";
        check_bit(tag, "phi1", phi1, e1);
        check_bit(tag, "phi2", phi2, e2);
        check_bit((tick == 0) ? "R8" : "R6", "strobe", strobe, es);
        check_bit("R5", "overlap", phi1 & phi2, 1'b0);
    endtask

    task automatic run_cycles(input int n, input bit r, input bit e);
        for (int i = 0; i < n; i++) begin
            rst = r;
            en  = e;
            @(negedge clk);
            compare_now(r);
        end
    endtask

    initial begin
        @(negedge clk);
        run_cycles(3, 1'b1, 1'b0);      // R1 reset state
        run_cycles(3, 1'b0, 1'b0);      // R7 idle while disabled
        run_cycles(3 * PER + 5, 1'b0, 1'b1);   // R2 R3 R4 R8 steady run
        run_cycles(1, 1'b0, 1'b0);      // R7 single-tick drop inside phi2/phi1
        run_cycles(PER + 3, 1'b0, 1'b1);
        run_cycles(4, 1'b0, 1'b0);      // R7 longer disable
        run_cycles(2 * PER, 1'b0, 1'b1);
        run_cycles(2, 1'b1, 1'b1);      // R1 reset while enabled
        run_cycles(2 * PER + 1, 1'b0, 1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule